// File: doc/BRIEF.md
# Serial Opcode Byte Decoder

The block takes a stream of machine-code bytes, one per cycle over a valid/ready handshake, and assembles it into whole instructions of a small 16-bit register-machine subset. The subset has four forms:

- a one-byte register increment;
- a one-byte register decrement;
- a load of an immediate value into a byte or word register;
- a move between a register and a register or memory operand, described by a second byte that carries a mode, a register and an rm field.

For every complete instruction the block presents one decoded record. Byte sequences outside the subset produce a record marked bad, and decoding resumes at the next byte.

Inside, a four-state machine tracks which byte it expects next:

- `ST_OPC` expects an opcode;
- `ST_MODRM` expects the mode byte;
- `ST_LO` expects the low data byte;
- `ST_HI` expects the high data byte.

The transitions, each taken only when a byte is accepted, are:

- `ST_OPC` stays in `ST_OPC` for increment, decrement or an unknown opcode, and goes to `ST_LO` for an immediate load or to `ST_MODRM` for a move.
- `ST_MODRM` goes to `ST_LO` when a direct offset follows, and otherwise returns to `ST_OPC`.
- `ST_LO` returns to `ST_OPC` for a byte immediate, and otherwise goes to `ST_HI`.
- `ST_HI` always returns to `ST_OPC`.

A finished record sits in a one-entry output register until the consumer takes it.

Record encodings:

- The kind codes are increment=0, decrement=1, immediate load=2, register/memory move=3 and bad=7.
- The addressing codes are register=0, register-indirect=1, direct offset=2 and immediate=3.
- Register numbers are 0..7.
- Fields not listed for a form are zero.

Top module: `opstream_decoder`

## Requirements
- R1: A synchronous reset clears `out_valid`, raises `in_ready`, and puts the machine in `ST_OPC`. A partly received instruction is dropped by the reset, so the next byte decodes as an opcode.
- R2: An opcode 01000rrr gives kind 0, wide=1, dst=src=rrr, dir=1, addressing 0, value 0 and length 1.
- R3: An opcode 01001rrr gives kind 1, with every other field the same as in R2.
- R4: An opcode 10111rrr followed by bytes L and H gives kind 2, wide=1, dst=rrr, src=0, dir=1, addressing 3, value {H,L} and length 3.
- R5: An opcode 10110rrr followed by byte L gives kind 2, wide=0, dst=rrr, src=0, dir=1, addressing 3, value {8'h00,L} and length 2.
- R6: An opcode 100010dw followed by a mode byte mm_ggg_nnn with mm=11 gives kind 3, wide=w, dir=d, addressing 0 and length 2. When d=1, dst=ggg and src=nnn; when d=0 the two are swapped.
- R7: With mm=00 and nnn=110, two offset bytes L and H follow. The record has addressing 2, value {H,L} and length 4, and the memory-side register number is 0 (src when d=1, dst when d=0).
- R8: With mm=00 and nnn equal to 100, 101 or 111, the record has addressing 1 and length 2. The memory-side register number is 6, 7 or 3 respectively.
- R9: A mode byte with mm=01, with mm=10, or with mm=00 and nnn in 000..011 gives a bad record: kind 7, bad=1, length 2 and value {8'h00, mode byte}. The following byte is decoded as an opcode.
- R10: An opcode outside the patterns of R2 to R6 gives a bad record: kind 7, bad=1, length 1 and value {8'h00, opcode}. The following byte is decoded as an opcode.
- R11: `out_valid` rises in the cycle after the final byte is accepted. While `out_ready` is low, the record and `out_valid` hold unchanged and `in_ready` is low.
- R12: A record can leave in the same cycle that the next instruction's final byte is accepted. A stream of one-byte instructions with the consumer always ready gives one record per cycle, with none lost.
- R13: Cycles with `in_valid` low are ignored, including in the middle of an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_byte | input | 8 | Instruction byte |
| in_valid | input | 1 | `in_byte` is offered |
| in_ready | output | 1 | Decoder can take a byte this cycle |
| out_ready | input | 1 | Consumer takes the record this cycle |
| out_valid | output | 1 | Decoded record is present |
| out_kind | output | 3 | Operation kind code |
| out_wide | output | 1 | 1 = word operands, 0 = byte operands |
| out_dst | output | 3 | Destination register number |
| out_src | output | 3 | Source register number |
| out_dir | output | 1 | Direction bit of the instruction |
| out_amode | output | 2 | Addressing code |
| out_value | output | 16 | Immediate, offset or offending byte |
| out_len | output | 3 | Instruction length in bytes |
| out_bad | output | 1 | Unsupported encoding |

## Verification
Two things can coincide in one clock edge: a held record being handed to the consumer, and the final byte of the next instruction being accepted and written into the output register. The bench provokes this with runs of one-byte instructions while the consumer is always ready, and with a consumer whose ready follows an alternating or pseudo-random pattern. Every record must appear exactly one cycle after its final byte, and must match the queued expectation in order, with none lost or duplicated. Stall cycles are judged by requiring that the held record stays unchanged and that `in_ready` is low.

// File: rtl/opdec_pkg.sv
`timescale 1ns/1ps
package opdec_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_W  = 3;
    localparam int VAL_W  = 2 * BYTE_W;
    localparam int LEN_W  = 3;
    localparam int MOD_W  = 2;

    localparam logic [MOD_W-1:0] MOD_REGREG = 2'b11;
    localparam logic [MOD_W-1:0] MOD_NODISP = 2'b00;
    localparam logic [REG_W-1:0] RM_DIRECT  = 3'b110;
    localparam logic [REG_W-1:0] RN_BASE    = 3'd3;
    localparam logic [REG_W-1:0] RN_SRCIDX  = 3'd6;
    localparam logic [REG_W-1:0] RN_DSTIDX  = 3'd7;

    typedef enum logic [2:0] {
        K_INC   = 3'd0,
        K_DEC   = 3'd1,
        K_MOVI  = 3'd2,
        K_MOVRM = 3'd3,
        K_BAD   = 3'd7
    } kind_e;

    typedef enum logic [1:0] {
        A_REG    = 2'd0,
        A_IND    = 2'd1,
        A_DIRECT = 2'd2,
        A_IMM    = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ST_OPC   = 2'd0,
        ST_MODRM = 2'd1,
        ST_LO    = 2'd2,
        ST_HI    = 2'd3
    } dec_state_e;

    typedef struct packed {
        kind_e             kind;
        logic              wide;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  src;
        logic              dir;
        amode_e            amode;
        logic [VAL_W-1:0]  value;
        logic [LEN_W-1:0]  len;
        logic              bad;
    } rec_t;
endpackage

// File: rtl/opdec_opcode_class.sv
`timescale 1ns/1ps
module opdec_opcode_class
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] opc,
    output kind_e             kind,
    output logic              w,
    output logic              d,
    output logic [REG_W-1:0]  r
);
    always_comb begin
        kind = K_BAD;
        w    = 1'b0;
        d    = 1'b0;
        r    = opc[REG_W-1:0];
        if (opc[7:3] == 5'b01000) begin
            kind = K_INC;
            w    = 1'b1;
        end else if (opc[7:3] == 5'b01001) begin
            kind = K_DEC;
            w    = 1'b1;
        end else if (opc[7:4] == 4'b1011) begin
            kind = K_MOVI;
            w    = opc[3];
        end else if (opc[7:2] == 6'b100010) begin
            kind = K_MOVRM;
            w    = opc[0];
            d    = opc[1];
        end
    end
endmodule

// File: rtl/opdec_modrm.sv
`timescale 1ns/1ps
module opdec_modrm
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] mrm,
    input  logic              d,
    output amode_e            amode,
    output logic              need_off,
    output logic              bad,
    output logic [REG_W-1:0]  dst,
    output logic [REG_W-1:0]  src
);
    logic [MOD_W-1:0] mf_mod;
    logic [REG_W-1:0] mf_reg;
    logic [REG_W-1:0] mf_rm;
    logic [REG_W-1:0] mem_reg;

    assign mf_mod = mrm[7:6];
    assign mf_reg = mrm[5:3];
    assign mf_rm  = mrm[2:0];

    always_comb begin
        amode    = A_REG;
        need_off = 1'b0;
        bad      = 1'b0;
        mem_reg  = '0;
        unique case (mf_mod)
            MOD_REGREG: begin
                mem_reg = mf_rm;
            end
            MOD_NODISP: begin
                if (mf_rm == RM_DIRECT) begin
                    amode    = A_DIRECT;
                    need_off = 1'b1;
                end else begin
                    amode = A_IND;
                    unique case (mf_rm)
                        3'b100:  mem_reg = RN_SRCIDX;
                        3'b101:  mem_reg = RN_DSTIDX;
                        3'b111:  mem_reg = RN_BASE;
                        default: bad = 1'b1;
                    endcase
                end
            end
            default: bad = 1'b1;
        endcase
    end

    assign dst = d ? mf_reg  : mem_reg;
    assign src = d ? mem_reg : mf_reg;
endmodule

// File: rtl/opdec_ctrl.sv
`timescale 1ns/1ps
module opdec_ctrl
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output rec_t              rec_q,
    input  kind_e             op_kind,
    input  logic              op_w,
    input  logic              op_d,
    input  logic [REG_W-1:0]  op_r,
    output logic              d_q,
    input  amode_e            mr_amode,
    input  logic              mr_need_off,
    input  logic              mr_bad,
    input  logic [REG_W-1:0]  mr_dst,
    input  logic [REG_W-1:0]  mr_src
);
    dec_state_e        state, nxt;
    kind_e             kind_q;
    logic              w_q;
    logic [REG_W-1:0]  r_q;
    logic [REG_W-1:0]  dst_q, src_q;
    logic [BYTE_W-1:0] lo_q;
    logic              acc;
    logic              emit;
    rec_t              erec;

    assign in_ready = !(out_valid && !out_ready);
    assign acc      = in_valid && in_ready;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_OPC;
        else     state <= nxt;
    end

    // fields held across the bytes of one instruction
    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= K_BAD;
            w_q    <= 1'b0;
            d_q    <= 1'b0;
            r_q    <= '0;
            dst_q  <= '0;
            src_q  <= '0;
            lo_q   <= '0;
        end else if (acc) begin
            unique case (state)
                ST_OPC: begin
                    kind_q <= op_kind;
                    w_q    <= op_w;
                    d_q    <= op_d;
                    r_q    <= op_r;
                end
                ST_MODRM: begin
                    dst_q <= mr_dst;
                    src_q <= mr_src;
                end
                ST_LO:   lo_q <= in_byte;
                ST_HI:   ;
            endcase
        end
    end

    // next state and record to emit
    always_comb begin
        nxt  = state;
        emit = 1'b0;
        erec = '0;
        unique case (state)
            ST_OPC: if (acc) begin
                unique case (op_kind)
                    K_INC, K_DEC: begin
                        emit       = 1'b1;
                        erec.kind  = op_kind;
                        erec.wide  = 1'b1;
                        erec.dst   = op_r;
                        erec.src   = op_r;
                        erec.dir   = 1'b1;
                        erec.amode = A_REG;
                        erec.len   = 3'd1;
                    end
                    K_MOVI:  nxt = ST_LO;
                    K_MOVRM: nxt = ST_MODRM;
                    default: begin
                        emit       = 1'b1;
                        erec.kind  = K_BAD;
                        erec.bad   = 1'b1;
                        erec.value = {{BYTE_W{1'b0}}, in_byte};
                        erec.len   = 3'd1;
                    end
                endcase
            end
            ST_MODRM: if (acc) begin
                if (mr_bad) begin
                    emit       = 1'b1;
                    nxt        = ST_OPC;
                    erec.kind  = K_BAD;
                    erec.bad   = 1'b1;
                    erec.value = {{BYTE_W{1'b0}}, in_byte};
                    erec.len   = 3'd2;
                end else if (mr_need_off) begin
                    nxt = ST_LO;
                end else begin
                    emit       = 1'b1;
                    nxt        = ST_OPC;
                    erec.kind  = K_MOVRM;
                    erec.wide  = w_q;
                    erec.dst   = mr_dst;
                    erec.src   = mr_src;
                    erec.dir   = d_q;
                    erec.amode = mr_amode;
                    erec.len   = 3'd2;
                end
            end
            ST_LO: if (acc) begin
                if (kind_q == K_MOVI && !w_q) begin
                    emit       = 1'b1;
                    nxt        = ST_OPC;
                    erec.kind  = K_MOVI;
                    erec.dst   = r_q;
                    erec.dir   = 1'b1;
                    erec.amode = A_IMM;
                    erec.value = {{BYTE_W{1'b0}}, in_byte};
                    erec.len   = 3'd2;
                end else begin
                    nxt = ST_HI;
                end
            end
            ST_HI: if (acc) begin
                emit       = 1'b1;
                nxt        = ST_OPC;
                erec.value = {in_byte, lo_q};
                erec.wide  = w_q;
                if (kind_q == K_MOVI) begin
                    erec.kind  = K_MOVI;
                    erec.dst   = r_q;
                    erec.dir   = 1'b1;
                    erec.amode = A_IMM;
                    erec.len   = 3'd3;
                end else begin
                    erec.kind  = K_MOVRM;
                    erec.dst   = dst_q;
                    erec.src   = src_q;
                    erec.dir   = d_q;
                    erec.amode = A_DIRECT;
                    erec.len   = 3'd4;
                end
            end
        endcase
    end

    // output record register
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            rec_q     <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            rec_q     <= erec;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state == ST_OPC) && !out_valid);

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(rec_q));

    // R11
    valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R2 R3
    incdec_shape_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && (rec_q.kind == K_INC || rec_q.kind == K_DEC)
            |-> rec_q.len == 3'd1 && rec_q.dst == rec_q.src);

    // R7
    direct_len_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && rec_q.amode == A_DIRECT
            |-> rec_q.len == 3'd4 && rec_q.kind == K_MOVRM);

    // R8
    ind_base_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && rec_q.amode == A_IND
            |-> ((rec_q.dir ? rec_q.src : rec_q.dst) == RN_BASE
              || (rec_q.dir ? rec_q.src : rec_q.dst) == RN_SRCIDX
              || (rec_q.dir ? rec_q.src : rec_q.dst) == RN_DSTIDX));

    // R9 R10
    bad_len_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid && rec_q.bad
            |-> (rec_q.len == 3'd1 || rec_q.len == 3'd2) && rec_q.kind == K_BAD);
endmodule

// File: rtl/opstream_decoder.sv
`timescale 1ns/1ps
module opstream_decoder
    import opdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [2:0]        out_kind,
    output logic              out_wide,
    output logic [REG_W-1:0]  out_dst,
    output logic [REG_W-1:0]  out_src,
    output logic              out_dir,
    output logic [1:0]        out_amode,
    output logic [VAL_W-1:0]  out_value,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_bad
);
    kind_e            op_kind;
    logic             op_w, op_d, d_q;
    logic [REG_W-1:0] op_r, mr_dst, mr_src;
    amode_e           mr_amode;
    logic             mr_need_off, mr_bad;
    rec_t             rec_q;

    opdec_opcode_class u_class (
        .opc  (in_byte),
        .kind (op_kind),
        .w    (op_w),
        .d    (op_d),
        .r    (op_r)
    );

    opdec_modrm u_modrm (
        .mrm      (in_byte),
        .d        (d_q),
        .amode    (mr_amode),
        .need_off (mr_need_off),
        .bad      (mr_bad),
        .dst      (mr_dst),
        .src      (mr_src)
    );

    opdec_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_byte     (in_byte),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .rec_q       (rec_q),
        .op_kind     (op_kind),
        .op_w        (op_w),
        .op_d        (op_d),
        .op_r        (op_r),
        .d_q         (d_q),
        .mr_amode    (mr_amode),
        .mr_need_off (mr_need_off),
        .mr_bad      (mr_bad),
        .mr_dst      (mr_dst),
        .mr_src      (mr_src)
    );

    assign out_kind  = rec_q.kind;
    assign out_wide  = rec_q.wide;
    assign out_dst   = rec_q.dst;
    assign out_src   = rec_q.src;
    assign out_dir   = rec_q.dir;
    assign out_amode = rec_q.amode;
    assign out_value = rec_q.value;
    assign out_len   = rec_q.len;
    assign out_bad   = rec_q.bad;
endmodule

// File: tb/test_opstream_decoder.sv
`timescale 1ns/1ps
module test_opstream_decoder;
    import opdec_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  in_byte = 8'h00;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        out_ready = 1'b1;
    logic        out_valid;
    logic [2:0]  o_kind;
    logic        o_wide, o_dir, o_bad;
    logic [2:0]  o_dst, o_src, o_len;
    logic [1:0]  o_amode;
    logic [15:0] o_value;
    rec_t        cur;

    opstream_decoder i_opstream_decoder (
        .clk(clk), .rst(rst), .in_byte(in_byte), .in_valid(in_valid),
        .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
        .out_kind(o_kind), .out_wide(o_wide), .out_dst(o_dst), .out_src(o_src),
        .out_dir(o_dir), .out_amode(o_amode), .out_value(o_value),
        .out_len(o_len), .out_bad(o_bad)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        cur.kind  = kind_e'(o_kind);
        cur.wide  = o_wide;
        cur.dst   = o_dst;
        cur.src   = o_src;
        cur.dir   = o_dir;
        cur.amode = amode_e'(o_amode);
        cur.value = o_value;
        cur.len   = o_len;
        cur.bad   = o_bad;
    end

    int checks = 0, errors = 0;
    typedef struct { rec_t r; int due; string tag; } exp_t;
    exp_t sbq[$];
    int rdy_mode = 0;
    bit gaps = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic rec_t mk(kind_e k, logic w, logic [2:0] dd, logic [2:0] ss,
                                logic dr, amode_e a, logic [15:0] v,
                                logic [2:0] n, logic b);
        rec_t t;
        t.kind = k; t.wide = w; t.dst = dd; t.src = ss; t.dir = dr;
        t.amode = a; t.value = v; t.len = n; t.bad = b;
        return t;
    endfunction

    task automatic put(input logic [7:0] b, output int c);
        bit done = 1'b0;
        c = 0;
        while (!done) begin
            @(negedge clk);
            #0.5;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (rdy_mode)
                0:       out_ready = 1'b1;
                1:       out_ready = cyc[0];
                default: out_ready = lfsr[0] | lfsr[3];
            endcase
            if (gaps && lfsr[5] && lfsr[7]) begin
                in_valid = 1'b0;
                in_byte  = 8'h40;   // R13: would decode as an increment if taken
            end else begin
                in_valid = 1'b1;
                in_byte  = b;
                #0.1;
                done = in_ready;
                c    = cyc;
            end
        end
    endtask

    task automatic send(input logic [7:0] b [4], input int n, input rec_t r, input string tag);
        int c;
        for (int i = 0; i < n; i++) put(b[i], c);
        sbq.push_back('{r, c + 1, tag});
    endtask

    task automatic drain();
        while (sbq.size() != 0 || out_valid) begin
            @(negedge clk);
            #0.5;
            in_valid  = 1'b0;
            out_ready = 1'b1;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic suite();
        for (int i = 0; i < 8; i++)
            send('{8'(8'h40 + i), 8'h00, 8'h00, 8'h00}, 1,
                 mk(K_INC, 1'b1, 3'(i), 3'(i), 1'b1, A_REG, 16'h0, 3'd1, 1'b0), "R2");
        for (int i = 0; i < 8; i++)
            send('{8'(8'h48 + i), 8'h00, 8'h00, 8'h00}, 1,
                 mk(K_DEC, 1'b1, 3'(i), 3'(i), 1'b1, A_REG, 16'h0, 3'd1, 1'b0), "R3");
        send('{8'hB8, 8'h00, 8'hFF, 8'h00}, 3, mk(K_MOVI, 1'b1, 3'd0, 3'd0, 1'b1, A_IMM, 16'hFF00, 3'd3, 1'b0), "R4");
        send('{8'hBB, 8'h34, 8'h12, 8'h00}, 3, mk(K_MOVI, 1'b1, 3'd3, 3'd0, 1'b1, A_IMM, 16'h1234, 3'd3, 1'b0), "R4");
        send('{8'hB0, 8'hFF, 8'h00, 8'h00}, 2, mk(K_MOVI, 1'b0, 3'd0, 3'd0, 1'b1, A_IMM, 16'h00FF, 3'd2, 1'b0), "R5");
        send('{8'hB7, 8'h5A, 8'h00, 8'h00}, 2, mk(K_MOVI, 1'b0, 3'd7, 3'd0, 1'b1, A_IMM, 16'h005A, 3'd2, 1'b0), "R5");
        send('{8'h8B, 8'hDD, 8'h00, 8'h00}, 2, mk(K_MOVRM, 1'b1, 3'd3, 3'd5, 1'b1, A_REG, 16'h0, 3'd2, 1'b0), "R6");
        send('{8'h89, 8'hDD, 8'h00, 8'h00}, 2, mk(K_MOVRM, 1'b1, 3'd5, 3'd3, 1'b0, A_REG, 16'h0, 3'd2, 1'b0), "R6");
        send('{8'h8A, 8'hDD, 8'h00, 8'h00}, 2, mk(K_MOVRM, 1'b0, 3'd3, 3'd5, 1'b1, A_REG, 16'h0, 3'd2, 1'b0), "R6");
        send('{8'h88, 8'hC1, 8'h00, 8'h00}, 2, mk(K_MOVRM, 1'b0, 3'd1, 3'd0, 1'b0, A_REG, 16'h0, 3'd2, 1'b0), "R6");
        send('{8'h8B, 8'h1E, 8'h00, 8'hF0}, 4, mk(K_MOVRM, 1'b1, 3'd3, 3'd0, 1'b1, A_DIRECT, 16'hF000, 3'd4, 1'b0), "R7");
        send('{8'h89, 8'h1E, 8'h34, 8'h12}, 4, mk(K_MOVRM, 1'b1, 3'd0, 3'd3, 1'b0, A_DIRECT, 16'h1234, 3'd4, 1'b0), "R7");
        send('{8'h8A, 8'h06, 8'hCD, 8'hAB}, 4, mk(K_MOVRM, 1'b0, 3'd0, 3'd0, 1'b1, A_DIRECT, 16'hABCD, 3'd4, 1'b0), "R7");
        send('{8'h8B, 8'h04, 8'h00, 8'h00}, 2, mk(K_MOVRM, 1'b1, 3'd0, 3'd6, 1'b1, A_IND, 16'h0, 3'd2, 1'b0), "R8");
        send('{8'h8B, 8'h3D, 8'h00, 8'h00}, 2, mk(K_MOVRM, 1'b1, 3'd7, 3'd7, 1'b1, A_IND, 16'h0, 3'd2, 1'b0), "R8");
        send('{8'h89, 8'h0F, 8'h00, 8'h00}, 2, mk(K_MOVRM, 1'b1, 3'd3, 3'd1, 1'b0, A_IND, 16'h0, 3'd2, 1'b0), "R8");
        send('{8'h8B, 8'h45, 8'h00, 8'h00}, 2, mk(K_BAD, 1'b0, 3'd0, 3'd0, 1'b0, A_REG, 16'h0045, 3'd2, 1'b1), "R9");
        send('{8'h41, 8'h00, 8'h00, 8'h00}, 1, mk(K_INC, 1'b1, 3'd1, 3'd1, 1'b1, A_REG, 16'h0, 3'd1, 1'b0), "R9");
        send('{8'h8B, 8'h80, 8'h00, 8'h00}, 2, mk(K_BAD, 1'b0, 3'd0, 3'd0, 1'b0, A_REG, 16'h0080, 3'd2, 1'b1), "R9");
        send('{8'h8A, 8'h00, 8'h00, 8'h00}, 2, mk(K_BAD, 1'b0, 3'd0, 3'd0, 1'b0, A_REG, 16'h0000, 3'd2, 1'b1), "R9");
        send('{8'h89, 8'h13, 8'h00, 8'h00}, 2, mk(K_BAD, 1'b0, 3'd0, 3'd0, 1'b0, A_REG, 16'h0013, 3'd2, 1'b1), "R9");
        send('{8'h90, 8'h00, 8'h00, 8'h00}, 1, mk(K_BAD, 1'b0, 3'd0, 3'd0, 1'b0, A_REG, 16'h0090, 3'd1, 1'b1), "R10");
        send('{8'h0F, 8'h00, 8'h00, 8'h00}, 1, mk(K_BAD, 1'b0, 3'd0, 3'd0, 1'b0, A_REG, 16'h000F, 3'd1, 1'b1), "R10");
        send('{8'h8C, 8'h00, 8'h00, 8'h00}, 1, mk(K_BAD, 1'b0, 3'd0, 3'd0, 1'b0, A_REG, 16'h008C, 3'd1, 1'b1), "R10");
        send('{8'h50, 8'h00, 8'h00, 8'h00}, 1, mk(K_BAD, 1'b0, 3'd0, 3'd0, 1'b0, A_REG, 16'h0050, 3'd1, 1'b1), "R10");
        send('{8'hB9, 8'h11, 8'h22, 8'h00}, 3, mk(K_MOVI, 1'b1, 3'd1, 3'd0, 1'b1, A_IMM, 16'h2211, 3'd3, 1'b0), "R10");
    endtask

    // scoreboard monitor
    logic pv = 1'b0, pr = 1'b0;
    rec_t prec;
    always @(negedge clk) begin
        #1;
        if (rst) begin
            pv = 1'b0;
            pr = 1'b0;
        end else begin
            if (out_valid && !out_ready) begin
                checks++;
                if (in_ready) begin
                    errors++;
                    $display("FAIL R11 stall: in_ready actual=%b expected=0", in_ready);
                end
            end
            if (pv && !pr) begin
                checks++;
                if (!out_valid || cur != prec) begin
                    errors++;
                    $display("FAIL R11 held record: actual valid=%b rec=%h expected valid=1 rec=%h",
                             out_valid, cur, prec);
                end
            end else if (out_valid) begin
                checks++;
                if (sbq.size() == 0) begin
                    errors++;
                    $display("FAIL R13 unexpected record: actual rec=%h expected none", cur);
                end else if (cyc != sbq[0].due) begin
                    errors++;
                    $display("FAIL %s timing: actual cycle=%0d expected cycle=%0d",
                             (pv && pr) ? "R12" : "R11", cyc, sbq[0].due);
                end
            end
            if (out_valid && out_ready && sbq.size() != 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if (cur != e.r) begin
                    errors++;
                    $display("FAIL %s record: actual=%h expected=%h", e.tag, cur, e.r);
                end
            end
            pv   = out_valid;
            pr   = out_ready;
            prec = cur;
        end
    end

    task automatic check_idle(input string tag);
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL %s reset state: actual valid=%b ready=%b expected valid=0 ready=1",
                     tag, out_valid, in_ready);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check_idle("R1");

        rdy_mode = 0; gaps = 1'b0; suite(); drain();   // R12 back-to-back
        rdy_mode = 1; gaps = 1'b1; suite(); drain();   // R11 R13
        rdy_mode = 2; gaps = 1'b1; suite(); drain();

        // R1: reset in the middle of an immediate load
        rdy_mode = 0; gaps = 1'b0;
        put(8'hB8, c);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check_idle("R1");
        send('{8'h41, 8'h00, 8'h00, 8'h00}, 1, mk(K_INC, 1'b1, 3'd1, 3'd1, 1'b1, A_REG, 16'h0, 3'd1, 1'b0), "R1");
        drain();

        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R12 lost records: actual pending=%0d expected 0", sbq.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule